// File: doc/BRIEF.md
# Likely-Branch Resolver

This block sits at the execute stage of a 32-bit pipelined processor and resolves the "likely" family of conditional branches. Each cycle it is given an instruction word, the two register operand values, the address of the instruction in the delay slot, and a condition flag from the system coprocessor. One cycle later it reports whether the word was a recognised likely branch, whether that branch is taken, the branch target, whether the delay-slot instruction must be cancelled, and whether a return address is to be written to the link register and what that address is.

A likely branch differs from an ordinary branch in one way. When its condition fails, the instruction already fetched into the delay slot is discarded. When the condition holds, the delay-slot instruction runs as usual. The two link variants write the return address whatever the outcome of the test.

Top module: `bl_resolve`

## Requirements
- R1: Opcode field bits [31:26]. The value 0x14 is taken when operand A equals operand B, and 0x15 is taken when they differ.
- R2: Opcode 0x16 is taken when operand A, read as signed 32-bit, is less than or equal to zero. Opcode 0x17 is taken when operand A is greater than zero.
- R3: With opcode 0x01 the sub-code in bits [20:16] selects the test. The value 0x02 is taken when A is below zero and 0x03 when A is at or above zero.
- R4: The link sub-codes are 0x12 (A below zero) and 0x13 (A at or above zero). For these, link_we=1, link_idx=31 and link_addr = slot address + 4, whether or not the branch is taken.
- R5: Opcode 0x10 with bits [25:21] equal to 0x08 is the coprocessor group. Sub-code 0x03 is taken when the flag is 1, and 0x02 when the flag is 0.
- R6: For every recognised branch, target = slot address + (sign-extended bits [15:0] shifted left 2), taken modulo 2^32.
- R7: A recognised branch that is not taken sets annul=1. A taken branch sets annul=0.
- R8: Any other word gives is_br=0, taken=0, annul=0, link_we=0, target=0, link_addr=0 and link_idx=0. A branch that does not link also gives link_addr=0 and link_idx=0.
- R9: All outputs are registered one cycle after the inputs. A synchronous active-high reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| slot_pc | input | 32 | Delay-slot instruction address |
| cp_cond | input | 1 | Coprocessor condition flag |
| is_br | output | 1 | Word is a recognised likely branch |
| taken | output | 1 | Branch taken |
| annul | output | 1 | Cancel the delay-slot instruction |
| target | output | 32 | Branch target address |
| link_we | output | 1 | Write the link register |
| link_idx | output | 5 | Link destination index |
| link_addr | output | 32 | Return address to write |

## Verification
Several rules are checked by assertions on every cycle. Annul is the complement of taken within a branch. Taken and annul are never raised without a branch, and a link write always targets index 31 with the return address one word past the target base. Reset clears the outputs, and every decision follows the inputs of the previous cycle. Only the bench's sweeps can show the rest: the correct opcode and sub-code map, the exact signed-zero boundaries (0, -1, most negative, most positive), and the wrapping of the target across 2^32.

// File: rtl/bl_resolve.sv
module bl_resolve #(
  parameter int XLEN = 32,
  parameter int LINK_REG = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] slot_pc,
  input  logic            cp_cond,
  output logic            is_br,
  output logic            taken,
  output logic            annul,
  output logic [XLEN-1:0] target,
  output logic            link_we,
  output logic [4:0]      link_idx,
  output logic [XLEN-1:0] link_addr
);
  localparam int OFFW = 16;

  logic [5:0] op;
  logic [4:0] f_rs, f_rt;
  assign op   = insn[31:26];
  assign f_rs = insn[25:21];
  assign f_rt = insn[20:16];

  logic a_neg, a_zero, a_eq_b;
  assign a_neg  = opa[XLEN-1];
  assign a_zero = ~|opa;
  assign a_eq_b = (opa == opb);

  logic [XLEN-1:0] disp;
  assign disp = {{(XLEN-OFFW-2){insn[OFFW-1]}}, insn[OFFW-1:0], 2'b00};

  logic dec_br, dec_cond, dec_link;
  always_comb begin
    dec_br   = 1'b1;
    dec_cond = 1'b0;
    dec_link = 1'b0;
    unique case (op)
      6'h14: dec_cond = a_eq_b;
      6'h15: dec_cond = ~a_eq_b;
      6'h16: dec_cond = a_neg | a_zero;
      6'h17: dec_cond = ~a_neg & ~a_zero;
      6'h01: begin
        unique case (f_rt)
          5'h02: dec_cond = a_neg;
          5'h03: dec_cond = ~a_neg;
          5'h12: begin dec_cond = a_neg;  dec_link = 1'b1; end
          5'h13: begin dec_cond = ~a_neg; dec_link = 1'b1; end
          default: dec_br = 1'b0;
        endcase
      end
      6'h10: begin
        if (f_rs == 5'h08 && f_rt == 5'h02)      dec_cond = ~cp_cond;
        else if (f_rs == 5'h08 && f_rt == 5'h03) dec_cond = cp_cond;
        else                                     dec_br   = 1'b0;
      end
      default: dec_br = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_br     <= 1'b0;
      taken     <= 1'b0;
      annul     <= 1'b0;
      target    <= '0;
      link_we   <= 1'b0;
      link_idx  <= '0;
      link_addr <= '0;
    end else begin
      is_br     <= dec_br;
      taken     <= dec_br & dec_cond;
      annul     <= dec_br & ~dec_cond;
      target    <= dec_br ? slot_pc + disp : '0;
      link_we   <= dec_br & dec_link;
      link_idx  <= (dec_br & dec_link) ? 5'(LINK_REG) : 5'd0;
      link_addr <= (dec_br & dec_link) ? slot_pc + XLEN'(4) : '0;
    end
  end

  // R7
  p_annul_excl_r7: assert property (@(posedge clk) disable iff (rst)
    is_br |-> (taken ^ annul));
  // R8
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !is_br |-> (!taken && !annul && !link_we && target == '0));
  // R4
  p_link_dest_r4: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (is_br && link_idx == 5'd31 && link_addr == $past(slot_pc) + XLEN'(4)));
  // R9
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (!is_br && !taken && !annul && !link_we && target == '0));
  // R5
  p_cp_true_r5: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(insn) == {6'h10, 5'h08, 5'h03, $past(insn[15:0])}) |-> (taken == $past(cp_cond)));
  // R9
  p_latency_r9: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(op) == 6'h14) |-> (is_br && taken == ($past(opa) == $past(opb))));
endmodule

// File: tb/bl_resolve_tb.sv
module bl_resolve_tb;
  logic clk = 0, rst = 1;
  logic [31:0] insn = 0, opa = 0, opb = 0, slot_pc = 0;
  logic cp_cond = 0;
  logic is_br, taken, annul, link_we;
  logic [31:0] target, link_addr;
  logic [4:0] link_idx;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bl_resolve u_dut (.clk, .rst, .insn, .opa, .opb, .slot_pc, .cp_cond,
    .is_br, .taken, .annul, .target, .link_we, .link_idx, .link_addr);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic [31:0] pc, logic c);
    insn = w; opa = a; opb = b; slot_pc = pc; cp_cond = c;
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] tgt(logic [31:0] w, logic [31:0] pc);
    return pc + {{14{w[15]}}, w[15:0], 2'b00};
  endfunction

  task automatic expect_br(string req, logic [31:0] w, logic [31:0] pc, bit tk, bit lk);
    chk(req, is_br, 1);
    chk(req, taken, tk);
    chk({req, "_R7"}, annul, !tk);
    chk({req, "_R6"}, target, tgt(w, pc));
    chk(req, link_we, lk);
    chk({req, "_R8"}, link_idx, lk ? 31 : 0);
    chk(req, link_addr, lk ? pc + 4 : 0);
  endtask

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                            32'h7FFF_FFFF, 32'h1234_5678, 32'hFFFF_FF00, 32'h2};

  initial begin
    @(posedge clk); #1;
    chk("R9", {is_br, taken, annul, link_we}, 0);
    chk("R9", target, 0);
    rst = 0;
    // R1 and R2 sweeps
    for (int o = 'h14; o <= 'h17; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          logic [31:0] w, pc;
          bit tk;
          logic signed [31:0] sa;
          w = {6'(o), 5'd3, 5'd4, 16'(i * 4099 + j * 77 - 300)};
          pc = 32'h0000_1000 + i * 64 + j * 4;
          sa = vals[i];
          case (o)
            'h14: tk = vals[i] == vals[j];
            'h15: tk = vals[i] != vals[j];
            'h16: tk = sa <= 0;
            default: tk = sa > 0;
          endcase
          apply(w, vals[i], vals[j], pc, 0);
          expect_br(o < 'h16 ? "R1" : "R2", w, pc, tk, 0);
        end
    // R3, R4
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 8; i++) begin
        logic [4:0] sc;
        logic [31:0] w, pc;
        bit tk;
        sc = (s == 0) ? 5'h02 : (s == 1) ? 5'h03 : (s == 2) ? 5'h12 : 5'h13;
        w = {6'h01, 5'd7, sc, 16'h8000 + 16'(i)};
        pc = 32'h0001_0000 + i * 4;
        tk = sc[0] ? !vals[i][31] : vals[i][31];
        apply(w, vals[i], 32'h5, pc, 0);
        expect_br(s < 2 ? "R3" : "R4", w, pc, tk, s >= 2);
      end
    // R5
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 2; c++) begin
        logic [31:0] w;
        w = {6'h10, 5'h08, 5'(2 + s), 16'h0010};
        apply(w, 0, 0, 32'h400, c[0]);
        expect_br("R5", w, 32'h400, s ? c[0] : !c[0], 0);
      end
    // R6 wrap
    apply({6'h14, 10'd0, 16'h0004}, 0, 0, 32'hFFFF_FFF8, 0);
    expect_br("R6", {6'h14, 10'd0, 16'h0004}, 32'hFFFF_FFF8, 1, 0);
    apply({6'h01, 5'd0, 5'h13, 16'h0}, 0, 0, 32'hFFFF_FFFC, 0);
    chk("R4", link_addr, 32'h0);
    // R8 non-branches
    for (int k = 0; k < 64; k++) begin
      logic [31:0] w;
      w = {6'(k), 5'h08, 5'h05, 16'hFFFF};
      if (k == 'h14 || k == 'h15 || k == 'h16 || k == 'h17) continue;
      apply(w, 32'hFFFF_FFFF, 0, 32'h100, 1);
      chk("R8", {is_br, taken, annul, link_we}, 0);
      chk("R8", target, 0);
      chk("R8", link_addr | 32'(link_idx), 0);
    end
    apply({6'h10, 5'h04, 5'h03, 16'h1}, 0, 0, 32'h100, 1);
    chk("R8", {is_br, taken, annul}, 0);
    // R9 reset mid-stream
    insn = {6'h15, 26'd1}; opa = 1; rst = 1;
    @(posedge clk); #1;
    chk("R9", {is_br, taken, annul, link_we}, 0);
    chk("R9", target, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); n_cmp++; n_bad++; $display("FAIL watchdog R9 act=hung exp=done"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule